// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block watches the command stream sent to a four-bank synchronous DRAM and decides, cycle by cycle, whether the command on its inputs respects the minimum spacing rules of the memory. It keeps per-bank down-counters for row timings and write recovery, plus a few global counters for spacing that spans banks. Every nanosecond limit is a parameter. It is converted to clock cycles at elaboration by dividing by the clock period and rounding up.

A controller uses `allowed_o` and `rule_o` combinationally to hold back a command until it is legal. A checker can instead let commands through and watch `viol_o`. When a command is presented while it is not allowed, a one-cycle violation pulse carrying the rule code appears on the next cycle. The block still updates its state as though the command had executed, so checking carries on afterwards. A separate per-bank age counter raises a warning when a row stays open longer than the maximum row-active time. This warning never blocks a command.

Top module: `sdram_cmd_guard`

## Requirements
- R1: After reset every bank is idle, `viol_o` and every bit of `ras_warn_o` are 0, and ACTIVE to any bank is allowed.
- R2: Two ACTIVE commands, to any banks, must be at least ceil(T_RRD_PS/CLK_PS) cycles apart; an early one gets rule code 2.
- R3: READ or WRITE to a bank must come at least ceil(T_RCD_PS/CLK_PS) cycles after its ACTIVE; an early one gets rule code 4.
- R4: PRECHARGE of an open bank must come at least ceil(T_RAS_PS/CLK_PS) cycles after its ACTIVE; an early one gets rule code 5.
- R5: ACTIVE to a bank needs at least ceil(T_RC_PS/CLK_PS) cycles since its previous ACTIVE and ceil(T_RP_PS/CLK_PS) cycles since its PRECHARGE; an early one gets rule code 3.
- R6: PRECHARGE of a bank needs at least T_RDL_CK cycles after the last write data-in cycle of that bank; this includes being blocked in the same cycle as that data-in. A violation gets rule code 6.
- R7: A WRITE with `cmd_auto_pre_i` set closes its bank at its last data-in cycle. ACTIVE to that bank is then allowed only T_DAL_CK + ceil(T_DAL_PS/CLK_PS) cycles later (rule code 3 before that). The bank stays open until that data-in cycle.
- R8: Column commands (READ, WRITE) may be issued on every cycle. A column command or BURST STOP needs at least T_CDL_CK or T_BDL_CK cycles after a last data-in (rule code 7).
- R9: ACTIVE to an open bank, or READ/WRITE to an idle bank, gets rule code 1. PRECHARGE of an idle bank is allowed and leaves the bank's timing untouched.
- R10: A command presented with `cmd_valid_i` while not allowed makes `viol_o` high for exactly the next cycle, with `viol_rule_o` equal to its rule code. The command's effect on bank state and counters is applied as if it were legal.
- R11: `ras_warn_o[b]` goes high once bank b has been open more than ceil(T_RAS_MAX_PS/CLK_PS) cycles. It stays low until then, and clears the cycle after the bank is precharged.
- R12: Opcodes: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 BURST STOP. Rule codes: 0 none, 1 bank state, 2 ACT-ACT any bank, 3 row cycle/precharge/auto-precharge recovery, 4 ACT-to-column, 5 minimum row active, 6 write-to-precharge, 7 write-to-column/burst stop. When several rules are broken, the bank-state rule is reported first. `allowed_o` is `cmd_valid_i` with rule 0, and `rule_o` is 0 when `cmd_valid_i` is low. NOP is always allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Opcode (R12 encoding) |
| cmd_bank_i | input | BA_W | Target bank |
| cmd_auto_pre_i | input | 1 | Auto-precharge, used with WRITE |
| wr_last_i | input | 1 | This cycle is the last write data-in cycle |
| wr_bank_i | input | BA_W | Bank of that last data-in |
| allowed_o | output | 1 | Presented command is legal now |
| rule_o | output | 3 | Rule the presented command would break |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_rule_o | output | 3 | Rule code of the violation |
| ras_warn_o | output | NUM_BANKS | Row open too long, per bank |

## Verification
The bench builds the guard at a 8000 ps clock with the default row limits. These give spacings of 2 (ACT-ACT), 3 (ACT-column), 3 (precharge), 6 (row active), 9 (row cycle) and 5 (auto-precharge recovery) cycles. The maximum row-active limit is shortened to 160000 ps (20 cycles) so the warning can be reached in a short run. For every spacing rule, the bench sweeps the gap from one cycle up to one past the limit and compares the allowed flag and rule code with values it computes from the same ceilings. Further checks cover same-cycle write recovery, auto-precharge with immediate and delayed data-in, back-to-back column commands, and a violating command whose state effect is then observed.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_BST = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    RULE_NONE   = 3'd0,
    RULE_STATE  = 3'd1,
    RULE_RRD    = 3'd2,
    RULE_ROWCYC = 3'd3,
    RULE_RCD    = 3'd4,
    RULE_RAS    = 3'd5,
    RULE_WRREC  = 3'd6,
    RULE_COLWR  = 3'd7
  } rule_e;

  function automatic int unsigned ps2cyc(int unsigned ps, int unsigned clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned cnt_w(int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  function automatic int unsigned less1(int unsigned c);
    return (c > 0) ? c - 1 : 0;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sdram_guard_cnt.sv
// Saturating down-counter: set overwrites, ext keeps the larger of value and count.
module sdram_guard_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic [W-1:0] set_val_i,
  input  logic         ext_i,
  input  logic [W-1:0] ext_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, dec, nxt;

  assign dec = (cnt_q == '0) ? '0 : cnt_q - W'(1);

  always_comb begin
    nxt = dec;
    if (set_i)      nxt = set_val_i;
    else if (ext_i) nxt = (ext_val_i > dec) ? ext_val_i : dec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt;
  end

  assign zero_o = (cnt_q == '0);

  // spacing counters fall by one per idle cycle (R2..R8 rely on it)
  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !ext_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

  assert_cnt_rest_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !ext_i && zero_o) |=> zero_o);

endmodule

// File: rtl/sdram_guard_bank.sv
module sdram_guard_bank
  import sdram_guard_pkg::*;
#(
  parameter int unsigned RCD_C    = 3,
  parameter int unsigned RAS_C    = 6,
  parameter int unsigned RC_C     = 9,
  parameter int unsigned RP_C     = 3,
  parameter int unsigned RDL_C    = 2,
  parameter int unsigned DAL_C    = 5,
  parameter int unsigned RASMAX_C = 12500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic wr_ap_i,
  input  logic pre_i,
  input  logic wr_last_i,
  output logic open_o,
  output logic rcd_zero_o,
  output logic ras_zero_o,
  output logic rc_zero_o,
  output logic rdl_zero_o,
  output logic ras_warn_o
);

  localparam int unsigned RCD_L = less1(RCD_C);
  localparam int unsigned RAS_L = less1(RAS_C);
  localparam int unsigned RC_L  = less1(RC_C);
  localparam int unsigned RP_L  = less1(RP_C);
  localparam int unsigned RDL_L = less1(RDL_C);
  localparam int unsigned DAL_L = less1(DAL_C);
  localparam int unsigned RCD_W = cnt_w(RCD_L);
  localparam int unsigned RAS_W = cnt_w(RAS_L);
  localparam int unsigned ROW_W = cnt_w(max3(RC_L, RP_L, DAL_L));
  localparam int unsigned RDL_W = cnt_w(RDL_L);
  localparam int unsigned AGE_W = cnt_w(RASMAX_C + 1);
  localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(RASMAX_C);

  logic             open_q, ap_q, close_wr;
  logic [AGE_W-1:0] age_q;
  logic [ROW_W-1:0] row_ext_val;

  assign close_wr = wr_last_i && (ap_q || wr_ap_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      ap_q   <= 1'b0;
    end else begin
      if (act_i)                    open_q <= 1'b1;
      else if (pre_i || close_wr)   open_q <= 1'b0;
      if (act_i || close_wr)        ap_q <= 1'b0;
      else if (wr_ap_i)             ap_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (act_i)           age_q <= AGE_W'(1);
    else if (!open_q)         age_q <= '0;
    else if (age_q <= AGE_LIM) age_q <= age_q + AGE_W'(1);
  end

  assign row_ext_val = close_wr ? ROW_W'(DAL_L) : ROW_W'(RP_L);

  sdram_guard_cnt #(.W(RCD_W)) u_rcd (
    .clk_i, .rst_ni, .set_i(act_i), .set_val_i(RCD_W'(RCD_L)),
    .ext_i(1'b0), .ext_val_i('0), .zero_o(rcd_zero_o));

  sdram_guard_cnt #(.W(RAS_W)) u_ras (
    .clk_i, .rst_ni, .set_i(act_i), .set_val_i(RAS_W'(RAS_L)),
    .ext_i(1'b0), .ext_val_i('0), .zero_o(ras_zero_o));

  sdram_guard_cnt #(.W(ROW_W)) u_row (
    .clk_i, .rst_ni, .set_i(act_i), .set_val_i(ROW_W'(RC_L)),
    .ext_i(pre_i || close_wr), .ext_val_i(row_ext_val), .zero_o(rc_zero_o));

  sdram_guard_cnt #(.W(RDL_W)) u_rdl (
    .clk_i, .rst_ni, .set_i(1'b0), .set_val_i('0),
    .ext_i(wr_last_i), .ext_val_i(RDL_W'(RDL_L)), .zero_o(rdl_zero_o));

  assign open_o     = open_q;
  assign ras_warn_o = open_q && (age_q > AGE_LIM);

  assert_act_opens_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> open_o);

  assert_warn_fresh_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> !ras_warn_o);

  assert_pre_clears_warn_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && !act_i) |=> !ras_warn_o && !open_o);

  assert_ap_close_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_wr && !act_i && DAL_C > 1) |=> !open_o && !rc_zero_o);

endmodule

// File: rtl/sdram_guard_global.sv
module sdram_guard_global
  import sdram_guard_pkg::*;
#(
  parameter int unsigned RRD_C = 2,
  parameter int unsigned CDL_C = 1,
  parameter int unsigned BDL_C = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic wr_last_i,
  output logic rrd_zero_o,
  output logic cdl_zero_o,
  output logic bdl_zero_o
);

  localparam int unsigned RRD_L = less1(RRD_C);
  localparam int unsigned CDL_L = less1(CDL_C);
  localparam int unsigned BDL_L = less1(BDL_C);
  localparam int unsigned RRD_W = cnt_w(RRD_L);
  localparam int unsigned CDL_W = cnt_w(CDL_L);
  localparam int unsigned BDL_W = cnt_w(BDL_L);

  sdram_guard_cnt #(.W(RRD_W)) u_rrd (
    .clk_i, .rst_ni, .set_i(act_i), .set_val_i(RRD_W'(RRD_L)),
    .ext_i(1'b0), .ext_val_i('0), .zero_o(rrd_zero_o));

  sdram_guard_cnt #(.W(CDL_W)) u_cdl (
    .clk_i, .rst_ni, .set_i(1'b0), .set_val_i('0),
    .ext_i(wr_last_i), .ext_val_i(CDL_W'(CDL_L)), .zero_o(cdl_zero_o));

  sdram_guard_cnt #(.W(BDL_W)) u_bdl (
    .clk_i, .rst_ni, .set_i(1'b0), .set_val_i('0),
    .ext_i(wr_last_i), .ext_val_i(BDL_W'(BDL_L)), .zero_o(bdl_zero_o));

  assert_rrd_block_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && RRD_C > 1) |=> !rrd_zero_o);

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdram_guard_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 4,
  parameter int unsigned CLK_PS        = 8000,
  parameter int unsigned T_RRD_PS      = 15000,
  parameter int unsigned T_RCD_PS      = 20000,
  parameter int unsigned T_RP_PS       = 20000,
  parameter int unsigned T_RAS_PS      = 45000,
  parameter int unsigned T_RAS_MAX_PS  = 100000000,
  parameter int unsigned T_RC_PS       = 65000,
  parameter int unsigned T_RDL_CK      = 2,
  parameter int unsigned T_CDL_CK      = 1,
  parameter int unsigned T_BDL_CK      = 1,
  parameter int unsigned T_DAL_CK      = 2,
  parameter int unsigned T_DAL_PS      = 20000,
  localparam int unsigned BA_W         = (NUM_BANKS < 2) ? 1 : $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  logic [2:0]           cmd_op_i,
  input  logic [BA_W-1:0]      cmd_bank_i,
  input  logic                 cmd_auto_pre_i,
  input  logic                 wr_last_i,
  input  logic [BA_W-1:0]      wr_bank_i,
  output logic                 allowed_o,
  output logic [2:0]           rule_o,
  output logic                 viol_o,
  output logic [2:0]           viol_rule_o,
  output logic [NUM_BANKS-1:0] ras_warn_o
);

  localparam int unsigned RRD_C    = ps2cyc(T_RRD_PS, CLK_PS);
  localparam int unsigned RCD_C    = ps2cyc(T_RCD_PS, CLK_PS);
  localparam int unsigned RP_C     = ps2cyc(T_RP_PS, CLK_PS);
  localparam int unsigned RAS_C    = ps2cyc(T_RAS_PS, CLK_PS);
  localparam int unsigned RASMAX_C = ps2cyc(T_RAS_MAX_PS, CLK_PS);
  localparam int unsigned RC_C     = ps2cyc(T_RC_PS, CLK_PS);
  localparam int unsigned DAL_C    = T_DAL_CK + ps2cyc(T_DAL_PS, CLK_PS);

  op_e   op;
  rule_e rule;
  logic  is_act, is_wr;

  logic [NUM_BANKS-1:0] open_b, rcd_z, ras_z, rc_z, rdl_z, wl_b;
  logic                 rrd_z, cdl_z, bdl_z;

  assign op     = op_e'(cmd_op_i);
  assign is_act = cmd_valid_i && (op == OP_ACT);
  assign is_wr  = cmd_valid_i && (op == OP_WR);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit     = (cmd_bank_i == BA_W'(b));
    assign wl_b[b] = wr_last_i && (wr_bank_i == BA_W'(b));

    sdram_guard_bank #(
      .RCD_C(RCD_C), .RAS_C(RAS_C), .RC_C(RC_C), .RP_C(RP_C),
      .RDL_C(T_RDL_CK), .DAL_C(DAL_C), .RASMAX_C(RASMAX_C)
    ) u_bank (
      .clk_i, .rst_ni,
      .act_i     (is_act && hit),
      .wr_ap_i   (is_wr && cmd_auto_pre_i && hit),
      .pre_i     (cmd_valid_i && (op == OP_PRE) && hit && open_b[b]),
      .wr_last_i (wl_b[b]),
      .open_o    (open_b[b]),
      .rcd_zero_o(rcd_z[b]),
      .ras_zero_o(ras_z[b]),
      .rc_zero_o (rc_z[b]),
      .rdl_zero_o(rdl_z[b]),
      .ras_warn_o(ras_warn_o[b])
    );
  end

  sdram_guard_global #(
    .RRD_C(RRD_C), .CDL_C(T_CDL_CK), .BDL_C(T_BDL_CK)
  ) u_global (
    .clk_i, .rst_ni,
    .act_i     (is_act),
    .wr_last_i (wr_last_i),
    .rrd_zero_o(rrd_z),
    .cdl_zero_o(cdl_z),
    .bdl_zero_o(bdl_z)
  );

  // Rule selection; bank state first, then the spacing counters.
  always_comb begin
    rule = RULE_NONE;
    if (cmd_valid_i) begin
      unique case (op)
        OP_ACT: begin
          if (open_b[cmd_bank_i])      rule = RULE_STATE;
          else if (!rc_z[cmd_bank_i])  rule = RULE_ROWCYC;
          else if (!rrd_z)             rule = RULE_RRD;
        end
        OP_RD, OP_WR: begin
          if (!open_b[cmd_bank_i])     rule = RULE_STATE;
          else if (!rcd_z[cmd_bank_i]) rule = RULE_RCD;
          else if (!cdl_z)             rule = RULE_COLWR;
        end
        OP_PRE: begin
          if (open_b[cmd_bank_i]) begin
            if (!ras_z[cmd_bank_i])    rule = RULE_RAS;
            else if (!rdl_z[cmd_bank_i] || (wl_b[cmd_bank_i] && T_RDL_CK > 0))
                                       rule = RULE_WRREC;
          end
        end
        OP_BST: begin
          if (!bdl_z)                  rule = RULE_COLWR;
        end
        default: rule = RULE_NONE;
      endcase
    end
  end

  assign rule_o    = rule;
  assign allowed_o = cmd_valid_i && (rule == RULE_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o      <= 1'b0;
      viol_rule_o <= '0;
    end else begin
      viol_o      <= cmd_valid_i && (rule != RULE_NONE);
      viol_rule_o <= rule;
    end
  end

  assert_legal_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    allowed_o |=> !viol_o);

  assert_illegal_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !allowed_o) |=> viol_o && (viol_rule_o != 3'd0));

  assert_nop_free_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && op == OP_NOP) |-> allowed_o);

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |-> (rule_o == 3'd0) && !allowed_o);

endmodule

// File: tb/sdram_cmd_guard_tb.sv
`timescale 1ns/1ps
module sdram_cmd_guard_tb;

  localparam int CK  = 8000;
  localparam int RMX = 160000;

  function automatic int cyc(int ps);
    return (ps + CK - 1) / CK;
  endfunction

  localparam int RRD = (15000 + CK - 1) / CK;
  localparam int RCD = (20000 + CK - 1) / CK;
  localparam int RP  = (20000 + CK - 1) / CK;
  localparam int RAS = (45000 + CK - 1) / CK;
  localparam int RC  = (65000 + CK - 1) / CK;
  localparam int RASMAX = (RMX + CK - 1) / CK;
  localparam int RDL = 2;
  localparam int DAL = 2 + (20000 + CK - 1) / CK;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4, BST = 3'd5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid = 1'b0;
  logic [2:0] op = '0;
  logic [1:0] bank = '0;
  logic       ap = 1'b0;
  logic       wl = 1'b0;
  logic [1:0] wbank = '0;
  logic       allowed_o, viol_o;
  logic [2:0] rule_o, viol_rule_o;
  logic [3:0] ras_warn_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdram_cmd_guard #(.CLK_PS(CK), .T_RAS_MAX_PS(RMX)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(valid), .cmd_op_i(op),
    .cmd_bank_i(bank), .cmd_auto_pre_i(ap), .wr_last_i(wl), .wr_bank_i(wbank),
    .allowed_o(allowed_o), .rule_o(rule_o), .viol_o(viol_o),
    .viol_rule_o(viol_rule_o), .ras_warn_o(ras_warn_o));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic idle();
    valid = 1'b0; op = NOP; bank = '0; ap = 1'b0; wl = 1'b0; wbank = '0;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    idle();
    rst_ni = 1'b0;
    wait_n(2);
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic drive(input logic [2:0] o, input logic [1:0] b, input logic a);
    valid = 1'b1; op = o; bank = b; ap = a;
  endtask

  // present, check rule and allowed, withdraw before the edge
  task automatic probe(input logic [2:0] o, input logic [1:0] b, input int exp, input string tag);
    drive(o, b, 1'b0);
    #1;
    chk(int'(rule_o) == exp, tag, int'(rule_o), exp);
    chk(allowed_o == (exp == 0), {tag, " allowed"}, int'(allowed_o), int'(exp == 0));
    valid = 1'b0;
  endtask

  task automatic issue(input logic [2:0] o, input logic [1:0] b, input logic a);
    drive(o, b, a);
    tick();
    idle();
  endtask

  task automatic issue_wl(input logic [2:0] o, input logic [1:0] b, input logic a,
                          input logic v, input logic [1:0] wb);
    drive(o, b, a);
    valid = v; wl = 1'b1; wbank = wb;
    tick();
    idle();
  endtask

  // executed command with its rule checked first
  task automatic issue_chk(input logic [2:0] o, input logic [1:0] b, input int exp, input string tag);
    drive(o, b, 1'b0);
    #1;
    chk(int'(rule_o) == exp, tag, int'(rule_o), exp);
    tick();
    idle();
  endtask

  initial begin
    do_reset();

    // R1 reset state
    chk(viol_o == 1'b0, "R1 viol", int'(viol_o), 0);
    chk(ras_warn_o == 4'd0, "R1 warn", int'(ras_warn_o), 0);
    for (int b = 0; b < 4; b++) probe(ACT, 2'(b), 0, "R1 act after reset");

    // R2 ACT-ACT any bank
    for (int k = 1; k <= RRD + 1; k++) begin
      do_reset(); issue(ACT, 0, 0); wait_n(k - 1);
      probe(ACT, 1, (k >= RRD) ? 0 : 2, "R2 rrd");
    end

    // R3 ACT to column
    for (int k = 1; k <= RCD + 1; k++) begin
      do_reset(); issue(ACT, 2, 0); wait_n(k - 1);
      probe(RD, 2, (k >= RCD) ? 0 : 4, "R3 rcd read");
      probe(WR, 2, (k >= RCD) ? 0 : 4, "R3 rcd write");
    end

    // R4 ACT to PRE
    for (int k = 1; k <= RAS + 1; k++) begin
      do_reset(); issue(ACT, 3, 0); wait_n(k - 1);
      probe(PRE, 3, (k >= RAS) ? 0 : 5, "R4 ras");
    end

    // R5 row cycle with precharge at the earliest point
    for (int k = RAS + 1; k <= RC + 1; k++) begin
      do_reset(); issue(ACT, 0, 0); wait_n(RAS - 1); issue(PRE, 0, 0);
      wait_n(k - RAS - 1);
      probe(ACT, 0, (k >= RC && (k - RAS) >= RP) ? 0 : 3, "R5 rc");
    end
    // R5 precharge to activate alone
    for (int j = 1; j <= RP + 1; j++) begin
      do_reset(); issue(ACT, 1, 0); wait_n(15); issue(PRE, 1, 0); wait_n(j - 1);
      probe(ACT, 1, (j >= RP) ? 0 : 3, "R5 rp");
    end

    // R6 write recovery before PRE
    for (int j = 1; j <= RDL + 1; j++) begin
      do_reset(); issue(ACT, 1, 0); wait_n(12); issue_wl(WR, 1, 0, 1, 1); wait_n(j - 1);
      probe(PRE, 1, (j >= RDL) ? 0 : 6, "R6 rdl");
    end
    do_reset(); issue(ACT, 1, 0); wait_n(12); issue(WR, 1, 0);
    drive(PRE, 1, 0); wl = 1'b1; wbank = 1; #1;
    chk(int'(rule_o) == 6, "R6 same cycle", int'(rule_o), 6);
    idle();

    // R7 auto-precharge recovery, data with the command
    for (int j = 1; j <= DAL + 1; j++) begin
      do_reset(); issue(ACT, 2, 0); wait_n(12); issue_wl(WR, 2, 1, 1, 2); wait_n(j - 1);
      if (j == 1) probe(RD, 2, 1, "R7 bank closed");
      probe(ACT, 2, (j >= DAL) ? 0 : 3, "R7 dal");
    end
    // R7 delayed last data-in
    do_reset(); issue(ACT, 2, 0); wait_n(12); issue(WR, 2, 1); wait_n(2);
    probe(ACT, 2, 1, "R7 open until data");
    issue_wl(NOP, 0, 0, 0, 2);
    wait_n(DAL - 2);
    probe(ACT, 2, 3, "R7 dal delayed early");
    tick();
    probe(ACT, 2, 0, "R7 dal delayed ok");

    // R8 column every cycle, column and BST after last data-in
    do_reset(); issue(ACT, 3, 0); wait_n(RCD - 1);
    issue_chk(RD, 3, 0, "R8 ccd rd");
    drive(WR, 3, 0); wl = 1'b1; wbank = 3; #1;
    chk(int'(rule_o) == 0, "R8 ccd wr", int'(rule_o), 0);
    tick(); idle();
    issue_chk(RD, 3, 0, "R8 cdl rd");
    issue_chk(BST, 3, 0, "R8 bdl");
    issue_chk(WR, 3, 0, "R8 ccd wr2");
    chk(viol_o == 1'b0, "R8 no violation", int'(viol_o), 0);

    // R9 bank state
    do_reset();
    probe(RD, 0, 1, "R9 read idle");
    probe(WR, 0, 1, "R9 write idle");
    issue(PRE, 0, 0);
    chk(viol_o == 1'b0, "R9 pre idle viol", int'(viol_o), 0);
    probe(ACT, 0, 0, "R9 pre idle no effect");
    issue(ACT, 0, 0); wait_n(RC);
    probe(ACT, 0, 1, "R9 act open");

    // R10 violation pulse and state update
    do_reset(); issue(ACT, 0, 0);
    issue_chk(ACT, 1, 2, "R10 early act");
    chk(viol_o == 1'b1, "R10 pulse", int'(viol_o), 1);
    chk(int'(viol_rule_o) == 2, "R10 code", int'(viol_rule_o), 2);
    tick();
    chk(viol_o == 1'b0, "R10 one cycle", int'(viol_o), 0);
    probe(RD, 1, (2 >= RCD) ? 0 : 4, "R10 state rcd");
    tick();
    probe(RD, 1, (3 >= RCD) ? 0 : 4, "R10 state rcd later");
    probe(ACT, 1, 1, "R10 bank opened");

    // R11 maximum row-active warning
    do_reset(); issue(ACT, 2, 0); wait_n(RASMAX - 1);
    chk(ras_warn_o == 4'd0, "R11 at limit", int'(ras_warn_o), 0);
    tick();
    chk(ras_warn_o == 4'b0100, "R11 past limit", int'(ras_warn_o), 4);
    issue(PRE, 2, 0);
    chk(ras_warn_o == 4'd0, "R11 cleared", int'(ras_warn_o), 0);

    // R12 NOP and idle encoding
    do_reset(); issue(ACT, 0, 0);
    probe(NOP, 0, 0, "R12 nop");
    #1;
    chk(allowed_o == 1'b0 && rule_o == 3'd0, "R12 no valid", int'(allowed_o), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule